// File: doc/BRIEF.md
# Split Translation Buffer with Set-Index Invalidation

This block holds two small translation buffers side by side: one serves instruction fetches and the other serves data accesses. Each buffer is two-way set-associative with 64 sets. An entry stores a valid flag, a virtual page tag and a physical page number. Each side has its own lookup port and its own translation enable. A single refill port writes new translations into either side. The refill picks the way to replace from a per-set least-recently-used bit.

Maintenance software uses a command port to manage the buffers. An invalidate command names a set and clears every way of that set in both buffers at once. It does not compare tags, and it does not care whether translation is enabled on either side. To empty both buffers, software sends 64 invalidates, one for each set number, and then one sync command. The sync holds the command port busy until every earlier invalidate has taken effect, and then it emits a one-cycle broadcast pulse. The encoding that would request a single-shot flush of everything is refused: it raises an illegal-operation pulse and changes nothing.

Top module: `split_xlat_buffer`

## Requirements
- R1: After synchronous reset, every lookup on both sides misses, `cmd_ready` is 1, and `sync_bcast` and `illegal_op` are 0.
- R2: A lookup request sampled at clock edge A returns its result registered at edge A+1. `*_lk_hit` is high for that one cycle, and `*_lk_ppn` carries the stored page number on a hit or zero on a miss.
- R3: The set index is the low 6 bits of a virtual page number, which are effective-address bits 17..12. The tag is the remaining 14 upper bits. A lookup hits only when the entry is valid and its tag matches, and a refill with `rf_side`=0 fills the instruction side while `rf_side`=1 fills the data side.
- R4: Refill writes the way named by the set's LRU bit and then points that bit at the other way. A lookup hit points the bit away from the way that hit. So two different tags can live in one set, and a third tag evicts the one used least recently.
- R5: An invalidate command (`cmd_op`=01) clears both ways of set `cmd_set` in both buffers. A lookup to that set presented in any cycle after the command's cycle misses, and other sets are not affected.
- R6: An invalidate ignores tags and ignores both translation enables: it clears the set even while `i_xlat_en` and `d_xlat_en` are 0.
- R7: A lookup on a side whose translation enable is 0 reports a miss.
- R8: Once a sync command (`cmd_op`=10) is accepted at edge S, `cmd_ready` and `sync_bcast` are 0 until edge S+1. After S+1, `sync_bcast` is 1 for exactly one cycle and `cmd_ready` is 1 again. The pulse comes only after every invalidate accepted before the sync has taken effect.
- R9: A flush-all command (`cmd_op`=11) raises `illegal_op` for one cycle after the accepting edge. It leaves every entry intact and produces no `sync_bcast`.
- R10: A refill to a set is dropped if it comes in the same cycle as an invalidate of that set, or in the cycle when that invalidate is being applied.
- R11: 64 invalidates with `cmd_set` stepping from 0 to 63, followed by a sync, leave every entry of both buffers invalid.
- R12: A command with `cmd_op`=00 is accepted but has no effect on any entry or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_xlat_en | input | 1 | Instruction-side translation enable |
| d_xlat_en | input | 1 | Data-side translation enable |
| i_lk_req | input | 1 | Instruction lookup request |
| i_lk_vpn | input | 20 | Instruction lookup virtual page number |
| i_lk_hit | output | 1 | Instruction lookup hit (registered) |
| i_lk_ppn | output | 20 | Instruction lookup physical page number |
| d_lk_req | input | 1 | Data lookup request |
| d_lk_vpn | input | 20 | Data lookup virtual page number |
| d_lk_hit | output | 1 | Data lookup hit (registered) |
| d_lk_ppn | output | 20 | Data lookup physical page number |
| rf_req | input | 1 | Refill write request |
| rf_side | input | 1 | Refill target: 0 instruction, 1 data |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_ppn | input | 20 | Refill physical page number |
| cmd_valid | input | 1 | Maintenance command valid |
| cmd_op | input | 2 | 00 none, 01 invalidate set, 10 sync, 11 flush-all (illegal) |
| cmd_set | input | 6 | Set to invalidate (effective-address bits 17..12) |
| cmd_ready | output | 1 | Command port can accept |
| sync_bcast | output | 1 | One-cycle sync broadcast pulse |
| illegal_op | output | 1 | One-cycle illegal-operation pulse |

## Verification
The checks assume that commands are offered only while `cmd_ready` is high. The bench drives `cmd_valid` only between sync handshakes, so no command ever waits on a busy port. The invalidate-miss property also assumes that no refill lands on the same set between the invalidate and the lookup that follows it. The stimulus keeps refills, lookups and commands in separate cycles, except where R10 deliberately puts them together. In every lookup the request stays up for exactly one cycle, so each registered result belongs to exactly one request.

// File: rtl/stlb_pkg.sv
package stlb_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_INVAL = 2'b01,
    OP_SYNC  = 2'b10,
    OP_FLUSH = 2'b11
  } stlb_op_e;
endpackage

// File: rtl/stlb_entry_ram.sv
module stlb_entry_ram #(
  parameter int AW = 6,
  parameter int DW = 34
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // write port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read, read-before-write
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/stlb_cmd_ctrl.sv
module stlb_cmd_ctrl
  import stlb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_set,
  output logic             cmd_ready,
  output logic             clr_v,
  output logic [IDX_W-1:0] clr_idx,
  output logic             sync_bcast,
  output logic             illegal_op
);
  logic sync_wait;
  logic acc;

  assign cmd_ready = !sync_wait;
  assign acc       = cmd_valid && cmd_ready;

  // pending-invalidate stage: accepted command applied one edge later
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_v <= 1'b0;
    end else begin
      clr_v <= acc && (cmd_op == OP_INVAL);
    end
    if (acc && (cmd_op == OP_INVAL)) clr_idx <= cmd_set;
  end

  // sync handshake and broadcast
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_wait  <= 1'b0;
      sync_bcast <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      illegal_op <= acc && (cmd_op == OP_FLUSH);
      sync_bcast <= sync_wait && !clr_v;
      if (sync_wait && !clr_v)
        sync_wait <= 1'b0;
      else if (acc && (cmd_op == OP_SYNC))
        sync_wait <= 1'b1;
    end
  end
endmodule

// File: rtl/stlb_bank.sv
module stlb_bank
  import stlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xlat_en,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             rf_req,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic             clr_v,
  input  logic [IDX_W-1:0] clr_idx
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int ENT_W = TAG_W + PPN_W;

  logic [SETS-1:0][WAYS-1:0] vld;
  logic [SETS-1:0]           lru;

  logic [IDX_W-1:0] lk_idx, rf_idx;
  logic [TAG_W-1:0] lk_tag, rf_tag;
  logic             victim;
  logic             rf_blocked;

  assign lk_idx     = lk_vpn[IDX_W-1:0];
  assign lk_tag     = lk_vpn[VPN_W-1:IDX_W];
  assign rf_idx     = rf_vpn[IDX_W-1:0];
  assign rf_tag     = rf_vpn[VPN_W-1:IDX_W];
  assign victim     = lru[rf_idx];
  assign rf_blocked = clr_v && (clr_idx == rf_idx);

  logic [WAYS-1:0][ENT_W-1:0] rd;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    stlb_entry_ram #(.AW(IDX_W), .DW(ENT_W)) u_ram (
      .clk   (clk),
      .we    (rf_req && (int'(victim) == w)),
      .waddr (rf_idx),
      .wdata ({rf_tag, rf_ppn}),
      .raddr (lk_idx),
      .rdata (rd[w])
    );
  end

  // stage 1: capture request and valid flags (masked by applying clear)
  logic             s1_v;
  logic [IDX_W-1:0] s1_idx;
  logic [TAG_W-1:0] s1_tag;
  logic [WAYS-1:0]  s1_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else begin
      s1_v <= lk_req && xlat_en;
    end
    s1_idx <= lk_idx;
    s1_tag <= lk_tag;
    s1_vld <= (clr_v && (clr_idx == lk_idx)) ? '0 : vld[lk_idx];
  end

  // stage 2: tag compare against RAM output
  logic [WAYS-1:0] hv;
  logic            any_hit;
  logic [PPN_W-1:0] sel_ppn;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = s1_vld[w] && (rd[w][ENT_W-1 -: TAG_W] == s1_tag);
  end

  assign any_hit = s1_v && (|hv);
  assign sel_ppn = hv[0] ? rd[0][PPN_W-1:0] : rd[1][PPN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit <= 1'b0;
      lk_ppn <= '0;
    end else begin
      lk_hit <= any_hit;
      lk_ppn <= any_hit ? sel_ppn : '0;
    end
  end

  // valid flags and replacement state; later statements take priority
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      lru <= '0;
    end else begin
      if (any_hit) lru[s1_idx] <= ~hv[1];
      if (rf_req) begin
        vld[rf_idx][victim] <= !rf_blocked;
        lru[rf_idx]         <= ~victim;
      end
      if (clr_v) vld[clr_idx] <= '0;
    end
  end
endmodule

// File: rtl/split_xlat_buffer.sv
module split_xlat_buffer
  import stlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_xlat_en,
  input  logic             d_xlat_en,
  input  logic             i_lk_req,
  input  logic [VPN_W-1:0] i_lk_vpn,
  output logic             i_lk_hit,
  output logic [PPN_W-1:0] i_lk_ppn,
  input  logic             d_lk_req,
  input  logic [VPN_W-1:0] d_lk_vpn,
  output logic             d_lk_hit,
  output logic [PPN_W-1:0] d_lk_ppn,
  input  logic             rf_req,
  input  logic             rf_side,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_set,
  output logic             cmd_ready,
  output logic             sync_bcast,
  output logic             illegal_op
);
  logic             clr_v;
  logic [IDX_W-1:0] clr_idx;

  stlb_cmd_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_set    (cmd_set),
    .cmd_ready  (cmd_ready),
    .clr_v      (clr_v),
    .clr_idx    (clr_idx),
    .sync_bcast (sync_bcast),
    .illegal_op (illegal_op)
  );

  stlb_bank #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_ibank (
    .clk     (clk),
    .rst     (rst),
    .xlat_en (i_xlat_en),
    .lk_req  (i_lk_req),
    .lk_vpn  (i_lk_vpn),
    .lk_hit  (i_lk_hit),
    .lk_ppn  (i_lk_ppn),
    .rf_req  (rf_req && !rf_side),
    .rf_vpn  (rf_vpn),
    .rf_ppn  (rf_ppn),
    .clr_v   (clr_v),
    .clr_idx (clr_idx)
  );

  stlb_bank #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_dbank (
    .clk     (clk),
    .rst     (rst),
    .xlat_en (d_xlat_en),
    .lk_req  (d_lk_req),
    .lk_vpn  (d_lk_vpn),
    .lk_hit  (d_lk_hit),
    .lk_ppn  (d_lk_ppn),
    .rf_req  (rf_req && rf_side),
    .rf_vpn  (rf_vpn),
    .rf_ppn  (rf_ppn),
    .clr_v   (clr_v),
    .clr_idx (clr_idx)
  );
endmodule

// File: rtl/split_xlat_buffer_chk.sv
module split_xlat_buffer_chk
  import stlb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [IDX_W-1:0] cmd_set,
  input logic             d_lk_req,
  input logic [IDX_W-1:0] d_lk_set,
  input logic             d_lk_hit,
  input logic             i_lk_req,
  input logic             i_xlat_en,
  input logic             i_lk_hit,
  input logic             sync_bcast,
  input logic             illegal_op
);
  logic inv_acc;
  assign inv_acc = cmd_valid && cmd_ready && (cmd_op == OP_INVAL);

  p_bcast_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    sync_bcast |=> !sync_bcast);

  p_sync_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_op == OP_SYNC)) |=> (!cmd_ready && !sync_bcast));

  p_bcast_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    sync_bcast |-> $past(!cmd_ready));

  p_illegal_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    illegal_op |=> !illegal_op);

  p_flush_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_op == OP_FLUSH)) |=> (illegal_op && !sync_bcast));

  p_hit_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    i_lk_hit |-> ($past(i_xlat_en, 2) && $past(i_lk_req, 2)));

  p_inval_miss_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(inv_acc) && d_lk_req && (d_lk_set == $past(cmd_set))) |=> ##1 !d_lk_hit);
endmodule

bind split_xlat_buffer split_xlat_buffer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .cmd_set    (cmd_set),
  .d_lk_req   (d_lk_req),
  .d_lk_set   (d_lk_vpn[IDX_W-1:0]),
  .d_lk_hit   (d_lk_hit),
  .i_lk_req   (i_lk_req),
  .i_xlat_en  (i_xlat_en),
  .i_lk_hit   (i_lk_hit),
  .sync_bcast (sync_bcast),
  .illegal_op (illegal_op)
);

// File: tb/split_xlat_buffer_test.sv
module split_xlat_buffer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        i_xlat_en = 1'b1, d_xlat_en = 1'b1;
  logic        i_lk_req = 1'b0, d_lk_req = 1'b0;
  logic [19:0] i_lk_vpn = '0, d_lk_vpn = '0;
  logic        i_lk_hit, d_lk_hit;
  logic [19:0] i_lk_ppn, d_lk_ppn;
  logic        rf_req = 1'b0, rf_side = 1'b0;
  logic [19:0] rf_vpn = '0, rf_ppn = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [5:0]  cmd_set = '0;
  logic        cmd_ready, sync_bcast, illegal_op;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  split_xlat_buffer uut (
    .clk(clk), .rst(rst), .i_xlat_en(i_xlat_en), .d_xlat_en(d_xlat_en),
    .i_lk_req(i_lk_req), .i_lk_vpn(i_lk_vpn), .i_lk_hit(i_lk_hit), .i_lk_ppn(i_lk_ppn),
    .d_lk_req(d_lk_req), .d_lk_vpn(d_lk_vpn), .d_lk_hit(d_lk_hit), .d_lk_ppn(d_lk_ppn),
    .rf_req(rf_req), .rf_side(rf_side), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_set(cmd_set), .cmd_ready(cmd_ready),
    .sync_bcast(sync_bcast), .illegal_op(illegal_op)
  );

  function automatic logic [19:0] vpn(input logic [13:0] tag, input logic [5:0] idx);
    return {tag, idx};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic refill(input bit side, input logic [19:0] v, input logic [19:0] p);
    @(negedge clk);
    rf_req = 1'b1; rf_side = side; rf_vpn = v; rf_ppn = p;
    @(negedge clk);
    rf_req = 1'b0;
  endtask

  task automatic look(input bit side, input logic [19:0] v, input bit exp_hit,
                      input logic [19:0] exp_ppn, input string req);
    logic h;
    logic [19:0] p;
    @(negedge clk);
    if (side) begin d_lk_req = 1'b1; d_lk_vpn = v; end
    else      begin i_lk_req = 1'b1; i_lk_vpn = v; end
    @(negedge clk);
    i_lk_req = 1'b0; d_lk_req = 1'b0;
    @(negedge clk);
    h = side ? d_lk_hit : i_lk_hit;
    p = side ? d_lk_ppn : i_lk_ppn;
    chk(h == exp_hit, req, "lookup hit", 32'(h), 32'(exp_hit));
    chk(p == (exp_hit ? exp_ppn : 20'h0), req, "lookup ppn", 32'(p),
        32'(exp_hit ? exp_ppn : 20'h0));
  endtask

  task automatic command(input logic [1:0] op, input logic [5:0] s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_set = s;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic sync_seq(input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, req, "ready during sync", 32'(cmd_ready), 0);
    chk(sync_bcast == 1'b0, req, "early bcast", 32'(sync_bcast), 0);
    @(negedge clk);
    chk(sync_bcast == 1'b1, req, "bcast pulse", 32'(sync_bcast), 1);
    chk(cmd_ready == 1'b1, req, "ready restored", 32'(cmd_ready), 1);
    @(negedge clk);
    chk(sync_bcast == 1'b0, req, "bcast one cycle", 32'(sync_bcast), 0);
  endtask

  task automatic t_reset;
    chk(cmd_ready == 1'b1, "R1", "ready", 32'(cmd_ready), 1);
    chk(sync_bcast == 1'b0, "R1", "bcast", 32'(sync_bcast), 0);
    chk(illegal_op == 1'b0, "R1", "illegal", 32'(illegal_op), 0);
    look(1'b0, vpn(14'h0, 6'd0), 1'b0, 20'h0, "R1");
    look(1'b1, vpn(14'h0, 6'd63), 1'b0, 20'h0, "R1");
  endtask

  task automatic t_refill_hit;
    refill(1'b0, vpn(14'h1a5, 6'd3), 20'hABCDE);
    look(1'b0, vpn(14'h1a5, 6'd3), 1'b1, 20'hABCDE, "R2");
    look(1'b1, vpn(14'h1a5, 6'd3), 1'b0, 20'h0, "R3");
    look(1'b0, vpn(14'h1a6, 6'd3), 1'b0, 20'h0, "R3");
  endtask

  task automatic t_lru;
    refill(1'b1, vpn(14'h011, 6'd5), 20'h11111);
    refill(1'b1, vpn(14'h022, 6'd5), 20'h22222);
    look(1'b1, vpn(14'h011, 6'd5), 1'b1, 20'h11111, "R4");
    look(1'b1, vpn(14'h022, 6'd5), 1'b1, 20'h22222, "R4");
    look(1'b1, vpn(14'h011, 6'd5), 1'b1, 20'h11111, "R4");
    refill(1'b1, vpn(14'h033, 6'd5), 20'h33333);
    look(1'b1, vpn(14'h011, 6'd5), 1'b1, 20'h11111, "R4");
    look(1'b1, vpn(14'h033, 6'd5), 1'b1, 20'h33333, "R4");
    look(1'b1, vpn(14'h022, 6'd5), 1'b0, 20'h0, "R4");
  endtask

  task automatic t_inval;
    refill(1'b0, vpn(14'h100, 6'd9), 20'h00901);
    refill(1'b0, vpn(14'h200, 6'd9), 20'h00902);
    refill(1'b1, vpn(14'h300, 6'd9), 20'h00903);
    refill(1'b0, vpn(14'h100, 6'd10), 20'h00A01);
    i_xlat_en = 1'b0; d_xlat_en = 1'b0;
    command(2'b01, 6'd9);
    @(negedge clk);
    i_xlat_en = 1'b1; d_xlat_en = 1'b1;
    look(1'b0, vpn(14'h100, 6'd9), 1'b0, 20'h0, "R6");
    look(1'b0, vpn(14'h200, 6'd9), 1'b0, 20'h0, "R5");
    look(1'b1, vpn(14'h300, 6'd9), 1'b0, 20'h0, "R5");
    look(1'b0, vpn(14'h100, 6'd10), 1'b1, 20'h00A01, "R5");
    // lookup in the very next cycle after the command
    refill(1'b1, vpn(14'h044, 6'd11), 20'h0B0B0);
    look(1'b1, vpn(14'h044, 6'd11), 1'b1, 20'h0B0B0, "R5");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_set = 6'd11;
    @(negedge clk);
    cmd_valid = 1'b0; d_lk_req = 1'b1; d_lk_vpn = vpn(14'h044, 6'd11);
    @(negedge clk);
    d_lk_req = 1'b0;
    @(negedge clk);
    chk(d_lk_hit == 1'b0, "R5", "next-cycle lookup", 32'(d_lk_hit), 0);
  endtask

  task automatic t_xlat_off;
    refill(1'b0, vpn(14'h055, 6'd12), 20'h0C0C0);
    i_xlat_en = 1'b0;
    look(1'b0, vpn(14'h055, 6'd12), 1'b0, 20'h0, "R7");
    i_xlat_en = 1'b1;
    look(1'b0, vpn(14'h055, 6'd12), 1'b1, 20'h0C0C0, "R7");
  endtask

  task automatic t_sync;
    refill(1'b1, vpn(14'h066, 6'd13), 20'h0D0D0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_set = 6'd13;
    sync_seq("R8");
    look(1'b1, vpn(14'h066, 6'd13), 1'b0, 20'h0, "R8");
  endtask

  task automatic t_flush;
    refill(1'b1, vpn(14'h077, 6'd14), 20'h0E0E0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11; cmd_set = 6'd14;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(illegal_op == 1'b1, "R9", "illegal pulse", 32'(illegal_op), 1);
    chk(sync_bcast == 1'b0, "R9", "no bcast", 32'(sync_bcast), 0);
    @(negedge clk);
    chk(illegal_op == 1'b0, "R9", "illegal one cycle", 32'(illegal_op), 0);
    look(1'b1, vpn(14'h077, 6'd14), 1'b1, 20'h0E0E0, "R9");
    look(1'b0, vpn(14'h1a5, 6'd3), 1'b1, 20'hABCDE, "R9");
  endtask

  task automatic t_collide;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_set = 6'd20;
    rf_req = 1'b1; rf_side = 1'b1; rf_vpn = vpn(14'h088, 6'd20); rf_ppn = 20'h14141;
    @(negedge clk);
    cmd_valid = 1'b0; rf_req = 1'b0;
    look(1'b1, vpn(14'h088, 6'd20), 1'b0, 20'h0, "R10");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_set = 6'd21;
    @(negedge clk);
    cmd_valid = 1'b0;
    rf_req = 1'b1; rf_side = 1'b0; rf_vpn = vpn(14'h099, 6'd21); rf_ppn = 20'h15151;
    @(negedge clk);
    rf_req = 1'b0;
    look(1'b0, vpn(14'h099, 6'd21), 1'b0, 20'h0, "R10");
    refill(1'b0, vpn(14'h099, 6'd21), 20'h15151);
    look(1'b0, vpn(14'h099, 6'd21), 1'b1, 20'h15151, "R10");
  endtask

  task automatic t_noop;
    command(2'b00, 6'd21);
    chk(illegal_op == 1'b0, "R12", "no illegal", 32'(illegal_op), 0);
    chk(sync_bcast == 1'b0, "R12", "no bcast", 32'(sync_bcast), 0);
    look(1'b0, vpn(14'h099, 6'd21), 1'b1, 20'h15151, "R12");
  endtask

  task automatic t_sweep;
    refill(1'b0, vpn(14'h3ff, 6'd0), 20'h00001);
    refill(1'b1, vpn(14'h123, 6'd31), 20'h00002);
    refill(1'b1, vpn(14'h321, 6'd63), 20'h00003);
    for (int k = 0; k < 64; k++) command(2'b01, 6'(k));
    sync_seq("R11");
    look(1'b0, vpn(14'h3ff, 6'd0), 1'b0, 20'h0, "R11");
    look(1'b1, vpn(14'h123, 6'd31), 1'b0, 20'h0, "R11");
    look(1'b1, vpn(14'h321, 6'd63), 1'b0, 20'h0, "R11");
    look(1'b1, vpn(14'h033, 6'd5), 1'b0, 20'h0, "R11");
    look(1'b0, vpn(14'h1a5, 6'd3), 1'b0, 20'h0, "R11");
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_refill_hit();
    t_lru();
    t_inval();
    t_xlat_off();
    t_sync();
    t_flush();
    t_collide();
    t_noop();
    t_sweep();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule